// File: doc/BRIEF.md
# Low-Voltage Programming Mode Entry and Exit Sequencer

This block owns the three target-facing wires of an in-circuit programming port: the target's active-low reset line, the serial clock and the serial data line. When asked to start, it walks the target into low-voltage programming mode. It drives all three wires low and gives reset one short high pulse. It then waits a long settling interval and clocks a fixed 32-bit entry key out on the data wire. After a short gap it raises reset and waits a data hold interval, and only then reports that the target is ready for programming commands.

When asked to stop, it parks clock and data low and pulls reset low for a short interval. It then releases reset and stops driving clock and data, so the target runs its own firmware again. Every interval is a parameter in clock cycles. Each default is derived from the system clock frequency, and any of them can be overridden with short values for simulation. A start or stop request that arrives at the wrong time is dropped. A busy flag covers every sequence, and a one-cycle done pulse marks the end of each one.

Top module: `prog_entry_seq`

## Requirements
- R1: After reset the block is idle. The target reset line is high, serial clock and data are 0 and not driven (drive enable 0), and busy, done and ready are 0.
- R2: A start request accepted while idle and not in programming mode begins entry in the next cycle. Clock, data and reset are driven low for T_SETUP cycles, then reset is high for T_PULSE cycles, then reset goes low again.
- R3: After reset falls the second time, reset stays low and the clock stays low for T_KEYWAIT cycles before the first rising clock edge.
- R4: The key 0x4D434850 is sent as 32 bits, most significant bit first. Each bit is one low clock phase of HALF cycles followed by one high clock phase of HALF cycles. The data wire holds the bit through both phases, and the clock is high at no other time.
- R5: After the last clock fall, clock and data stay low with reset low for T_GAP cycles. Reset is then driven high for T_HOLD cycles, and after that the block enters programming mode.
- R6: A stop request accepted in programming mode parks clock and data low with reset high for T_PARK cycles. Reset is then driven low for T_XLOW cycles. After that reset is high and the clock and data wires are released (drive enable 0).
- R7: busy is high in every cycle of an entry or exit sequence and low otherwise. done is high for exactly one cycle, the first cycle after a sequence ends.
- R8: Start and stop requests are ignored while busy. A start request is ignored in programming mode, and a stop request is ignored while idle.
- R9: ready is high exactly while the block is in programming mode, from the done cycle of entry until an accepted stop request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to enter programming mode |
| stop_i | input | 1 | Request to leave programming mode |
| tgt_rst_o | output | 1 | Target reset line level (low holds the target in reset) |
| tgt_clk_o | output | 1 | Serial programming clock |
| tgt_dat_o | output | 1 | Serial programming data |
| tgt_drv_o | output | 1 | Drive enable for the clock and data wires |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| ready_o | output | 1 | Target is in programming mode |

## Verification
Every cycle of every entry and exit sequence is compared with a waveform that a bench function computes from the phase lengths. A design with one cycle too many or too few in any phase, with the key bits reversed, or with the data changing within a clock high phase therefore fails at the first wrong cycle. Start and stop requests are injected at random cycles during sequences and in the wrong mode. A design that restarts or aborts on them would stop matching the expected waveform. A reset in the middle of the key must return the wires to their released state at once. A design that resumed the key after reset, or left the wires driven, fails the idle checks that follow.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  localparam int unsigned KEY_W = 32;
  localparam logic [KEY_W-1:0] ENTRY_KEY = 32'h4D43_4850;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_E_LOW,
    ST_E_PULSE,
    ST_E_WAIT,
    ST_K_LO,
    ST_K_HI,
    ST_E_GAP,
    ST_E_HOLD,
    ST_ACTIVE,
    ST_X_PARK,
    ST_X_LOW
  } seq_state_t;

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/key_shifter.sv
module key_shifter #(
  parameter int unsigned     W   = 32,
  parameter logic [W-1:0]    KEY = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic shift_i,
  output logic bit_o,
  output logic last_o
);

  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]     sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             sh_en;

  assign sh_en = load_i || shift_i;

  always_comb begin
    if (load_i) begin
      sh_d  = KEY;
      idx_d = '0;
    end else begin
      sh_d  = {sh_q[W-2:0], 1'b0};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign bit_o  = sh_q[W-1];
  assign last_o = (idx_q == IDX_W'(W-1));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import prog_seq_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned T_SETUP    = 1,
  parameter int unsigned T_PULSE    = 1,
  parameter int unsigned T_KEYWAIT  = 1,
  parameter int unsigned HALF       = 1,
  parameter int unsigned T_GAP      = 1,
  parameter int unsigned T_HOLD     = 1,
  parameter int unsigned T_PARK     = 1,
  parameter int unsigned T_XLOW     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tmr_zero_i,
  input  logic             key_last_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             key_load_o,
  output logic             key_shift_o,
  output logic             done_o,
  output seq_state_t       state_o
);

  seq_state_t state_q, state_d;
  logic       done_q, done_d;

  function automatic logic [CNT_W-1:0] phase_len(seq_state_t s);
    int unsigned n;
    case (s)
      ST_E_LOW:   n = T_SETUP;
      ST_E_PULSE: n = T_PULSE;
      ST_E_WAIT:  n = T_KEYWAIT;
      ST_K_LO:    n = HALF;
      ST_K_HI:    n = HALF;
      ST_E_GAP:   n = T_GAP;
      ST_E_HOLD:  n = T_HOLD;
      ST_X_PARK:  n = T_PARK;
      ST_X_LOW:   n = T_XLOW;
      default:    n = 1;
    endcase
    return CNT_W'(n - 1);
  endfunction

  always_comb begin
    state_d     = state_q;
    done_d      = 1'b0;
    key_load_o  = 1'b0;
    key_shift_o = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d    = ST_E_LOW;
        key_load_o = 1'b1;
      end
      ST_E_LOW:   if (tmr_zero_i) state_d = ST_E_PULSE;
      ST_E_PULSE: if (tmr_zero_i) state_d = ST_E_WAIT;
      ST_E_WAIT:  if (tmr_zero_i) state_d = ST_K_LO;
      ST_K_LO:    if (tmr_zero_i) state_d = ST_K_HI;
      ST_K_HI: if (tmr_zero_i) begin
        if (key_last_i) begin
          state_d = ST_E_GAP;
        end else begin
          state_d     = ST_K_LO;
          key_shift_o = 1'b1;
        end
      end
      ST_E_GAP:   if (tmr_zero_i) state_d = ST_E_HOLD;
      ST_E_HOLD: if (tmr_zero_i) begin
        state_d = ST_ACTIVE;
        done_d  = 1'b1;
      end
      ST_ACTIVE:  if (stop_i) state_d = ST_X_PARK;
      ST_X_PARK:  if (tmr_zero_i) state_d = ST_X_LOW;
      ST_X_LOW: if (tmr_zero_i) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  assign tmr_load_o = (state_d != state_q);
  assign tmr_val_o  = phase_len(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign done_o  = done_q;
  assign state_o = state_q;

endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq
  import prog_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 4_000_000,
  parameter int unsigned CYC_PER_US = (CLK_HZ >= 1_000_000) ? CLK_HZ / 1_000_000 : 1,
  parameter int unsigned T_SETUP    = CYC_PER_US,
  parameter int unsigned T_PULSE    = CYC_PER_US,
  parameter int unsigned T_KEYWAIT  = 4000 * CYC_PER_US,
  parameter int unsigned HALF       = CYC_PER_US,
  parameter int unsigned T_GAP      = CYC_PER_US,
  parameter int unsigned T_HOLD     = 400 * CYC_PER_US,
  parameter int unsigned T_PARK     = CYC_PER_US,
  parameter int unsigned T_XLOW     = 3 * CYC_PER_US
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic tgt_rst_o,
  output logic tgt_clk_o,
  output logic tgt_dat_o,
  output logic tgt_drv_o,
  output logic busy_o,
  output logic done_o,
  output logic ready_o
);

  localparam int unsigned T_MAX = T_SETUP + T_PULSE + T_KEYWAIT + HALF +
                                  T_GAP + T_HOLD + T_PARK + T_XLOW;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  logic             rst_meta_q, rst_sync_q;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             key_load, key_shift, key_bit, key_last;
  seq_state_t       state;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  seq_ctrl #(
    .CNT_W(CNT_W), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
    .T_KEYWAIT(T_KEYWAIT), .HALF(HALF), .T_GAP(T_GAP),
    .T_HOLD(T_HOLD), .T_PARK(T_PARK), .T_XLOW(T_XLOW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .tmr_zero_i (tmr_zero),
    .key_last_i (key_last),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .key_load_o (key_load),
    .key_shift_o(key_shift),
    .done_o     (done_o),
    .state_o    (state)
  );

  phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  key_shifter #(.W(KEY_W), .KEY(ENTRY_KEY)) u_key (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .load_i (key_load),
    .shift_i(key_shift),
    .bit_o  (key_bit),
    .last_o (key_last)
  );

  always_comb begin
    tgt_rst_o = 1'b0;
    tgt_clk_o = 1'b0;
    tgt_dat_o = 1'b0;
    tgt_drv_o = (state != ST_IDLE);
    busy_o    = (state != ST_IDLE) && (state != ST_ACTIVE);
    ready_o   = (state == ST_ACTIVE);
    case (state)
      ST_IDLE, ST_E_PULSE, ST_E_HOLD, ST_ACTIVE, ST_X_PARK: tgt_rst_o = 1'b1;
      ST_K_LO: tgt_dat_o = key_bit;
      ST_K_HI: begin
        tgt_dat_o = key_bit;
        tgt_clk_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/prog_entry_seq_chk.sv
module prog_entry_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input logic tgt_rst_o,
  input logic tgt_clk_o,
  input logic tgt_dat_o,
  input logic tgt_drv_o,
  input logic busy_o,
  input logic done_o,
  input logic ready_o
);

  // R1: outside programming mode and sequences the wires are released
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !ready_o) |-> (tgt_rst_o && !tgt_drv_o && !tgt_clk_o && !tgt_dat_o));

  // R4: clock is only ever high during a sequence
  p_clk_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_clk_o |-> busy_o);

  // R4: data holds while the clock is high
  p_dat_stable_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_clk_o && $past(busy_o)) |-> $stable(tgt_dat_o));

  // R7: done lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: done follows a busy cycle and is not itself busy
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9: ready and busy never overlap
  p_ready_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!busy_o && tgt_rst_o && tgt_drv_o));

  // R8: a stop request in programming mode starts busy next cycle
  p_stop_accepted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && stop_i) |=> busy_o);

endmodule

bind prog_entry_seq prog_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .tgt_rst_o(tgt_rst_o), .tgt_clk_o(tgt_clk_o), .tgt_dat_o(tgt_dat_o),
  .tgt_drv_o(tgt_drv_o), .busy_o(busy_o), .done_o(done_o), .ready_o(ready_o)
);

// File: tb/tb_prog_entry_seq.sv
`timescale 1ns/1ps
module tb_prog_entry_seq;

  localparam int S = 2, P = 3, W = 5, H = 2, G = 2, HD = 4, PK = 2, XL = 3;
  localparam int KEYT = 64 * H;
  localparam int ENTRY_LEN = S + P + W + KEYT + G + HD;
  localparam int EXIT_LEN = PK + XL;
  localparam logic [31:0] KEY = 32'h4D43_4850;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic stop_i = 1'b0;
  logic tgt_rst_o, tgt_clk_o, tgt_dat_o, tgt_drv_o, busy_o, done_o, ready_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prog_entry_seq #(
    .T_SETUP(S), .T_PULSE(P), .T_KEYWAIT(W), .HALF(H), .T_GAP(G),
    .T_HOLD(HD), .T_PARK(PK), .T_XLOW(XL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .tgt_rst_o(tgt_rst_o), .tgt_clk_o(tgt_clk_o), .tgt_dat_o(tgt_dat_o),
    .tgt_drv_o(tgt_drv_o), .busy_o(busy_o), .done_o(done_o), .ready_o(ready_o)
  );

  // vector order: {rst, drv, clk, dat, busy, ready, done}
  function automatic logic [6:0] obs();
    return {tgt_rst_o, tgt_drv_o, tgt_clk_o, tgt_dat_o, busy_o, ready_o, done_o};
  endfunction

  localparam logic [6:0] V_IDLE   = 7'b1000000;
  localparam logic [6:0] V_ACTIVE = 7'b1100010;

  function automatic logic [6:0] exp_entry(int t, output string tag);
    int k, b;
    if (t < S) begin tag = "R2"; return 7'b0100100; end
    if (t < S + P) begin tag = "R2"; return 7'b1100100; end
    if (t < S + P + W) begin tag = "R3"; return 7'b0100100; end
    if (t < S + P + W + KEYT) begin
      k = t - (S + P + W);
      b = k / (2 * H);
      tag = "R4";
      return {1'b0, 1'b1, ((k % (2 * H)) >= H), KEY[31 - b], 3'b100};
    end
    if (t < S + P + W + KEYT + G) begin tag = "R5"; return 7'b0100100; end
    if (t < ENTRY_LEN) begin tag = "R5"; return 7'b1100100; end
    tag = "R7";
    return 7'b1100011;
  endfunction

  function automatic logic [6:0] exp_exit(int t, output string tag);
    tag = "R6";
    if (t < PK) return 7'b1100100;
    if (t < EXIT_LEN) return 7'b0100100;
    tag = "R7";
    return 7'b1000001;
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // run a sequence from the negedge where the request is driven
  task automatic run_entry(bit noise);
    string tag;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t <= ENTRY_LEN; t++) begin
      check(tag, obs(), exp_entry(t, tag));
      start_i = noise && (t < ENTRY_LEN) && ($urandom_range(0, 3) == 0); // R8
      stop_i  = noise && (t < ENTRY_LEN) && ($urandom_range(0, 3) == 0); // R8
      @(negedge clk);
    end
    start_i = 1'b0;
    stop_i = 1'b0;
  endtask

  task automatic run_exit(bit noise);
    string tag;
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    for (int t = 0; t <= EXIT_LEN; t++) begin
      check(tag, obs(), exp_exit(t, tag));
      start_i = noise && (t < EXIT_LEN) && ($urandom_range(0, 2) == 0); // R8
      stop_i  = noise && (t < EXIT_LEN) && ($urandom_range(0, 2) == 0); // R8
      @(negedge clk);
    end
    start_i = 1'b0;
    stop_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1", obs(), V_IDLE);          // R1 during reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", obs(), V_IDLE);          // R1 after release

    // R8: stop while idle is ignored
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    repeat (2) begin check("R8", obs(), V_IDLE); @(negedge clk); end

    run_entry(1'b0);                     // directed clean entry
    check("R9", obs(), V_ACTIVE);
    // R8: start in programming mode is ignored
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) begin check("R8", obs(), V_ACTIVE); @(negedge clk); end
    run_exit(1'b0);
    @(negedge clk);
    check("R1", obs(), V_IDLE);

    for (int it = 0; it < 6; it++) begin
      repeat ($urandom_range(0, 5)) begin check("R1", obs(), V_IDLE); @(negedge clk); end
      run_entry(1'b1);
      repeat ($urandom_range(0, 5)) begin check("R9", obs(), V_ACTIVE); @(negedge clk); end
      run_exit(1'b1);
    end

    // reset in the middle of the key returns the wires to idle at once (R1)
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (S + P + W + 20) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R1", obs(), V_IDLE);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", obs(), V_IDLE);
    run_entry(1'b0);                     // fresh entry sends the whole key (R4)
    run_exit(1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule